// File: doc/BRIEF.md
# Indirect flash transfer controller

This block moves blocks of bytes between a flash-side byte stream and a host-side word buffer without the host ever touching the flash bus. Software loads a byte count and a flash start address for one direction, writes a start bit and then services a word buffer: in the read direction it pops 32-bit words as soon as the read level is nonzero, and in the write direction it pushes 32-bit words and waits for the write level to drain to zero before pushing the next page. Each direction has its own control word with start, cancel, in-progress and done bits, and the done bit stays set until software writes a one to it.

The flash side is a plain byte handshake. For reads the block raises a request with the current address and takes a byte in every cycle where the flash side marks it valid. For writes it offers a byte and its address and advances when the flash side acknowledges. Bytes are packed into words little-endian (first byte in bits 7:0). One storage array holds both buffers and is split at a programmable word index, half the depth by default.

Register select codes on `reg_sel`: 0 read control, 1 read byte count, 2 read start address, 3 write control, 4 write byte count, 5 write start address, 6 fill levels, 7 partition point. Control word bits: 0 start, 1 cancel, 2 in-progress (read-only), 5 done (write one to clear).

Top module: `ixfer_ctrl`

## Requirements
- R1: After reset both control words, both fill levels and both flash requests are zero, and the partition register reads BUF_WORDS/2.
- R2: Writing start (control bit 0) to an idle direction with a nonzero count loads the count and address registers; in-progress (bit 2) reads one from the next cycle, and flash addresses run upward from the start address by one per transferred byte.
- R3: Read bytes are packed little-endian, first byte in bits 7:0; a final word holding fewer than four bytes carries zeros in its unused upper lanes.
- R4: When the last byte of a transfer is moved, in-progress falls and done (bit 5) rises at the same clock edge; done stays set until a write with bit 5 set, and a control write with bit 5 clear leaves it set.
- R5: Writing cancel (bit 1) returns that direction to idle in the next cycle with done left clear and its flash request low; a byte handed over in the cancel cycle is discarded, and cancel wins over a start in the same write.
- R6: Writing start while that direction is in progress is ignored: the running transfer keeps its count and addresses.
- R7: The fill-level word (select 6) reports the read-buffer level in bits 15:0 and the write-buffer level in bits 31:16, in 32-bit words.
- R8: The read request is held low while the read level equals the read partition size and resumes once the host pops a word; host pops of an empty read buffer are ignored.
- R9: For writes, bytes leave the head word lowest lane first, the head word is released after its fourth byte or the last byte of the transfer, and the write request is held low while the write buffer is empty.
- R10: The write partition holds BUF_WORDS minus the partition point; a host push into a full write partition is ignored. A partition write is taken only while both directions are idle, is clamped to 1..BUF_WORDS-1, and empties both buffers.
- R11: Start with a byte count of zero sets done at once without ever raising in-progress or a flash request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| hrd_pop | input | 1 | Host pops the read-buffer head word |
| hrd_data | output | 32 | Read-buffer head word |
| hwr_push | input | 1 | Host pushes a word into the write buffer |
| hwr_data | input | 32 | Word pushed by the host |
| fr_req | output | 1 | Read byte request |
| fr_addr | output | ADDR_W | Flash address of the requested read byte |
| fr_vld | input | 1 | Flash side delivers a read byte |
| fr_byte | input | 8 | Delivered read byte |
| fw_req | output | 1 | Write byte offered |
| fw_addr | output | ADDR_W | Flash address of the offered write byte |
| fw_byte | output | 8 | Offered write byte |
| fw_ack | input | 1 | Flash side takes the offered byte |

## Verification
Reads are run with a flash side that is always valid and with one that stalls every third cycle, at byte counts that end on a word boundary and off it, so the lane packing and zero padding are told apart from a fixed four-byte step. A read longer than the read partition with the host not popping separates real back-pressure from overflow, and shrinking the partition repeats that at a second size. Writes are run with and without words waiting in the buffer and with a stalling acknowledge, which separates lane order and head release from request gating; restart-while-busy, cancel, zero-count and partition writes while busy check the control handshake corners.

// File: rtl/ixfer_pkg.sv
package ixfer_pkg;

  localparam int CTL_START  = 0;
  localparam int CTL_CANCEL = 1;
  localparam int CTL_BUSY   = 2;
  localparam int CTL_DONE   = 5;

  typedef enum logic [2:0] {
    SEL_RCTL  = 3'd0,
    SEL_RCNT  = 3'd1,
    SEL_RADDR = 3'd2,
    SEL_WCTL  = 3'd3,
    SEL_WCNT  = 3'd4,
    SEL_WADDR = 3'd5,
    SEL_LVL   = 3'd6,
    SEL_PART  = 3'd7
  } reg_sel_e;

  // Place a byte into lane idx of a word whose higher lanes are zero.
  function automatic logic [31:0] lane_insert(logic [31:0] w, logic [1:0] idx, logic [7:0] b);
    return w | ({24'b0, b} << {idx, 3'b000});
  endfunction

  // Pick lane idx of a word.
  function automatic logic [7:0] lane_pick(logic [31:0] w, logic [1:0] idx);
    logic [31:0] t;
    t = w >> {idx, 3'b000};
    return t[7:0];
  endfunction

  // Readback image of a control word.
  function automatic logic [31:0] ctl_image(logic busy, logic done);
    logic [31:0] v;
    v = '0;
    v[CTL_BUSY] = busy;
    v[CTL_DONE] = done;
    return v;
  endfunction

endpackage

// File: rtl/ixfer_buf.sv
module ixfer_buf #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          part_we,
  input  logic [PW-1:0] part_wdata,
  input  logic          rpush,
  input  logic [31:0]   rpush_data,
  input  logic          rpop,
  input  logic          wpush,
  input  logic [31:0]   wpush_data,
  input  logic          wpop,
  output logic [31:0]   rhead,
  output logic [31:0]   whead,
  output logic [LW-1:0] rlvl,
  output logic [LW-1:0] wlvl,
  output logic [PW-1:0] part,
  output logic          rspace,
  output logic          wavail
);

  localparam logic [PW-1:0] PDEF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] part_q, rwp_q, rrp_q, wwp_q, wrp_q;
  logic [LW-1:0] rlvl_q, wlvl_q;
  logic [LW-1:0] wcap;
  logic          rpop_ok, wpush_ok, wpop_ok;

  // Advance a pointer inside the region [base, last].
  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p, logic [PW-1:0] base,
                                             logic [PW-1:0] last);
    return (p == last) ? base : p + PW'(1);
  endfunction

  assign wcap     = LW'(DEPTH) - LW'(part_q);
  assign rpop_ok  = rpop && (rlvl_q != '0);
  assign wpush_ok = wpush && (wlvl_q < wcap);
  assign wpop_ok  = wpop && (wlvl_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= PDEF;
      rwp_q  <= '0;
      rrp_q  <= '0;
      wwp_q  <= PDEF;
      wrp_q  <= PDEF;
      rlvl_q <= '0;
      wlvl_q <= '0;
    end else if (part_we) begin
      part_q <= part_wdata;
      rwp_q  <= '0;
      rrp_q  <= '0;
      wwp_q  <= part_wdata;
      wrp_q  <= part_wdata;
      rlvl_q <= '0;
      wlvl_q <= '0;
    end else begin
      if (rpush)    rwp_q <= ptr_next(rwp_q, '0, part_q - PW'(1));
      if (rpop_ok)  rrp_q <= ptr_next(rrp_q, '0, part_q - PW'(1));
      if (wpush_ok) wwp_q <= ptr_next(wwp_q, part_q, PMAX);
      if (wpop_ok)  wrp_q <= ptr_next(wrp_q, part_q, PMAX);
      rlvl_q <= rlvl_q + LW'(rpush) - LW'(rpop_ok);
      wlvl_q <= wlvl_q + LW'(wpush_ok) - LW'(wpop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!part_we && rpush)    mem[rwp_q] <= rpush_data;
    if (!part_we && wpush_ok) mem[wwp_q] <= wpush_data;
  end

  assign rhead  = mem[rrp_q];
  assign whead  = mem[wrp_q];
  assign rlvl   = rlvl_q;
  assign wlvl   = wlvl_q;
  assign part   = part_q;
  assign rspace = rlvl_q < LW'(part_q);
  assign wavail = wlvl_q != '0;

endmodule

// File: rtl/ixfer_rd_eng.sv
module ixfer_rd_eng
  import ixfer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              space_ok,
  input  logic              vld,
  input  logic [7:0]        byte_in,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              push,
  output logic [31:0]       push_word,
  output logic              busy,
  output logic              done_evt,
  output logic              take
);

  logic              busy_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        idx_q;
  logic [31:0]       asm_q;
  logic              last, word_end, start_ok;

  assign req       = busy_q && space_ok;
  assign take      = req && vld;
  assign last      = rem_q == CNT_W'(1);
  assign word_end  = take && ((idx_q == 2'd3) || last);
  assign push_word = lane_insert(asm_q, idx_q, byte_in);
  assign push      = word_end && !cancel;
  assign start_ok  = start && !busy_q && !cancel;
  assign done_evt  = (take && last && !cancel) || (start_ok && (cnt_in == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      idx_q  <= '0;
      asm_q  <= '0;
    end else if (cancel) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      asm_q  <= '0;
    end else if (start_ok) begin
      busy_q <= cnt_in != '0;
      rem_q  <= cnt_in;
      addr_q <= addr_in;
      idx_q  <= '0;
      asm_q  <= '0;
    end else if (take) begin
      rem_q  <= rem_q - CNT_W'(1);
      addr_q <= addr_q + ADDR_W'(1);
      idx_q  <= idx_q + 2'd1;
      asm_q  <= word_end ? 32'd0 : push_word;
      if (last) busy_q <= 1'b0;
    end
  end

  assign addr = addr_q;
  assign busy = busy_q;

endmodule

// File: rtl/ixfer_wr_eng.sv
module ixfer_wr_eng
  import ixfer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              avail,
  input  logic [31:0]       head,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        byte_out,
  output logic              pop,
  output logic              busy,
  output logic              done_evt,
  output logic              take
);

  logic              busy_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        idx_q;
  logic              last, start_ok;

  assign req      = busy_q && avail;
  assign take     = req && ack;
  assign last     = rem_q == CNT_W'(1);
  assign byte_out = lane_pick(head, idx_q);
  assign pop      = take && ((idx_q == 2'd3) || last) && !cancel;
  assign start_ok = start && !busy_q && !cancel;
  assign done_evt = (take && last && !cancel) || (start_ok && (cnt_in == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      idx_q  <= '0;
    end else if (cancel) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_ok) begin
      busy_q <= cnt_in != '0;
      rem_q  <= cnt_in;
      addr_q <= addr_in;
      idx_q  <= '0;
    end else if (take) begin
      rem_q  <= rem_q - CNT_W'(1);
      addr_q <= addr_q + ADDR_W'(1);
      idx_q  <= last ? 2'd0 : idx_q + 2'd1;
      if (last) busy_q <= 1'b0;
    end
  end

  assign addr = addr_q;
  assign busy = busy_q;

endmodule

// File: rtl/ixfer_ctrl.sv
module ixfer_ctrl
  import ixfer_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hrd_pop,
  output logic [31:0]       hrd_data,
  input  logic              hwr_push,
  input  logic [31:0]       hwr_data,
  output logic              fr_req,
  output logic [ADDR_W-1:0] fr_addr,
  input  logic              fr_vld,
  input  logic [7:0]        fr_byte,
  output logic              fw_req,
  output logic [ADDR_W-1:0] fw_addr,
  output logic [7:0]        fw_byte,
  input  logic              fw_ack
);

  localparam int PW = $clog2(BUF_WORDS);
  localparam int LW = $clog2(BUF_WORDS + 1);

  logic [CNT_W-1:0]  rd_cnt_q, wr_cnt_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic              rd_done_q, wr_done_q;

  // Named events for the checker
  logic rd_start_w, rd_cancel_w, rd_clr_w, wr_start_w, wr_cancel_w, wr_clr_w;
  logic rd_busy, wr_busy, rd_done_evt, wr_done_evt, rd_take, wr_take;
  logic rd_push, wr_pop, part_we;
  logic [31:0]   rd_push_word, whead;
  logic [LW-1:0] rlvl, wlvl;
  logic [PW-1:0] part_q, part_wdata;
  logic          rspace, wavail;

  function automatic logic [PW-1:0] part_clamp(logic [31:0] v);
    if (v == 32'd0) return PW'(1);
    if (v >= 32'(BUF_WORDS)) return PW'(BUF_WORDS - 1);
    return v[PW-1:0];
  endfunction

  assign rd_start_w  = reg_we && (reg_sel == SEL_RCTL) && reg_wdata[CTL_START];
  assign rd_cancel_w = reg_we && (reg_sel == SEL_RCTL) && reg_wdata[CTL_CANCEL];
  assign rd_clr_w    = reg_we && (reg_sel == SEL_RCTL) && reg_wdata[CTL_DONE];
  assign wr_start_w  = reg_we && (reg_sel == SEL_WCTL) && reg_wdata[CTL_START];
  assign wr_cancel_w = reg_we && (reg_sel == SEL_WCTL) && reg_wdata[CTL_CANCEL];
  assign wr_clr_w    = reg_we && (reg_sel == SEL_WCTL) && reg_wdata[CTL_DONE];
  assign part_we     = reg_we && (reg_sel == SEL_PART) && !rd_busy && !wr_busy;
  assign part_wdata  = part_clamp(reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q  <= '0;
      wr_cnt_q  <= '0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      rd_done_q <= 1'b0;
      wr_done_q <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_RCNT)  rd_cnt_q  <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_sel == SEL_WCNT)  wr_cnt_q  <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_sel == SEL_RADDR) rd_addr_q <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_sel == SEL_WADDR) wr_addr_q <= reg_wdata[ADDR_W-1:0];
      if (rd_done_evt)   rd_done_q <= 1'b1;
      else if (rd_clr_w) rd_done_q <= 1'b0;
      if (wr_done_evt)   wr_done_q <= 1'b1;
      else if (wr_clr_w) wr_done_q <= 1'b0;
    end
  end

  ixfer_rd_eng #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start_w), .cancel(rd_cancel_w),
    .cnt_in(rd_cnt_q), .addr_in(rd_addr_q), .space_ok(rspace),
    .vld(fr_vld), .byte_in(fr_byte), .req(fr_req), .addr(fr_addr),
    .push(rd_push), .push_word(rd_push_word), .busy(rd_busy),
    .done_evt(rd_done_evt), .take(rd_take)
  );

  ixfer_wr_eng #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(wr_start_w), .cancel(wr_cancel_w),
    .cnt_in(wr_cnt_q), .addr_in(wr_addr_q), .avail(wavail), .head(whead),
    .ack(fw_ack), .req(fw_req), .addr(fw_addr), .byte_out(fw_byte),
    .pop(wr_pop), .busy(wr_busy), .done_evt(wr_done_evt), .take(wr_take)
  );

  ixfer_buf #(.DEPTH(BUF_WORDS), .PW(PW), .LW(LW)) u_buf (
    .clk(clk), .rst_n(rst_n), .part_we(part_we), .part_wdata(part_wdata),
    .rpush(rd_push), .rpush_data(rd_push_word), .rpop(hrd_pop),
    .wpush(hwr_push), .wpush_data(hwr_data), .wpop(wr_pop),
    .rhead(hrd_data), .whead(whead), .rlvl(rlvl), .wlvl(wlvl),
    .part(part_q), .rspace(rspace), .wavail(wavail)
  );

  always_comb begin
    case (reg_sel)
      SEL_RCTL:  reg_rdata = ctl_image(rd_busy, rd_done_q);
      SEL_RCNT:  reg_rdata = 32'(rd_cnt_q);
      SEL_RADDR: reg_rdata = 32'(rd_addr_q);
      SEL_WCTL:  reg_rdata = ctl_image(wr_busy, wr_done_q);
      SEL_WCNT:  reg_rdata = 32'(wr_cnt_q);
      SEL_WADDR: reg_rdata = 32'(wr_addr_q);
      SEL_LVL:   reg_rdata = {16'(wlvl), 16'(rlvl)};
      default:   reg_rdata = 32'(part_q);
    endcase
  end

endmodule

// File: rtl/ixfer_chk.sv
module ixfer_chk #(
  parameter int DEPTH  = 16,
  parameter int PW     = 4,
  parameter int LW     = 5,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_busy,
  input logic              wr_busy,
  input logic              rd_done_q,
  input logic              wr_done_q,
  input logic              rd_start_w,
  input logic              rd_cancel_w,
  input logic              wr_cancel_w,
  input logic              rd_take,
  input logic              rd_push,
  input logic              fr_req,
  input logic              fw_req,
  input logic [ADDR_W-1:0] fr_addr,
  input logic [LW-1:0]     rlvl,
  input logic [LW-1:0]     wlvl,
  input logic [PW-1:0]     part_q
);

  // R2
  rd_busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy) |-> $past(rd_start_w));

  // R4
  rd_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done_q) |-> !rd_busy);

  // R4
  wr_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done_q) |-> !wr_busy);

  // R5
  rd_cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cancel_w |=> !rd_busy && !fr_req);

  // R5
  wr_cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cancel_w |=> !wr_busy && !fw_req);

  // R6
  rd_restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy && rd_start_w && !rd_take && !rd_cancel_w |=> $stable(fr_addr));

  // R8
  rd_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_req |-> (rlvl < LW'(part_q)));

  // R8
  rd_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> (rlvl < LW'(part_q)));

  // R9
  wr_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_req |-> (wlvl != '0));

  // R10
  wr_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wlvl <= LW'(DEPTH) - LW'(part_q));

endmodule

bind ixfer_ctrl ixfer_chk #(.DEPTH(BUF_WORDS), .PW(PW), .LW(LW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_busy(rd_busy), .wr_busy(wr_busy),
  .rd_done_q(rd_done_q), .wr_done_q(wr_done_q), .rd_start_w(rd_start_w),
  .rd_cancel_w(rd_cancel_w), .wr_cancel_w(wr_cancel_w), .rd_take(rd_take),
  .rd_push(rd_push), .fr_req(fr_req), .fw_req(fw_req), .fr_addr(fr_addr),
  .rlvl(rlvl), .wlvl(wlvl), .part_q(part_q)
);

// File: tb/tb_ixfer_ctrl.sv
module tb_ixfer_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd6;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hrd_pop = 1'b0;
  logic [31:0] hrd_data;
  logic        hwr_push = 1'b0;
  logic [31:0] hwr_data = '0;
  logic        fr_req;
  logic [31:0] fr_addr;
  logic        fr_vld = 1'b0;
  logic [7:0]  fr_byte = '0;
  logic        fw_req;
  logic [31:0] fw_addr;
  logic [7:0]  fw_byte;
  logic        fw_ack = 1'b0;

  ixfer_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ncyc = 0;

  // stimulus variables
  bit          s_we = 0;
  bit   [2:0]  s_sel = 3'd6;
  bit   [31:0] s_wdata = 0;
  bit          s_pop = 0, s_push = 0;
  bit   [31:0] s_pdata = 0;
  int          vld_mode = 0, ack_mode = 0;

  // sampled values
  bit   [31:0] last_rdata, last_hrd, last_fw_addr;
  bit          last_fr_req, last_fw_req;
  bit   [7:0]  last_fw_byte;

  // reference model state
  bit          m_rbusy, m_rdone, m_wbusy, m_wdone;
  int          m_rrem, m_ridx, m_wrem, m_widx, m_part;
  bit   [31:0] m_raddr, m_waddr, m_rasm;
  bit   [31:0] m_rcnt, m_rareg, m_wcnt, m_wareg;
  bit   [31:0] rq[$];
  bit   [31:0] wq[$];

  function automatic bit [7:0] bdata(bit [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic bit [31:0] m_reg(bit [2:0] sel);
    case (sel)
      3'd0: return (32'(m_rdone) << 5) | (32'(m_rbusy) << 2);
      3'd1: return m_rcnt;
      3'd2: return m_rareg;
      3'd3: return (32'(m_wdone) << 5) | (32'(m_wbusy) << 2);
      3'd4: return m_wcnt;
      3'd5: return m_wareg;
      3'd6: return (32'(wq.size()) << 16) | 32'(rq.size());
      default: return 32'(m_part);
    endcase
  endfunction

  function automatic string sel_tag(bit [2:0] sel);
    case (sel)
      3'd0, 3'd3: return "R4";
      3'd6: return "R7";
      3'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit rtake, wtake, rctl, wctl, rstart, rcancel, rclr, wstart, wcancel, wclr;
    bit rdone_evt, wdone_evt, rpush, wpop, pop_ok, push_ok, part_we;
    bit [31:0] word, cval;
    bit [7:0] b;
    rtake = m_rbusy && (rq.size() < m_part) && fr_vld;
    wtake = m_wbusy && (wq.size() > 0) && fw_ack;
    rctl = s_we && s_sel == 3'd0;
    wctl = s_we && s_sel == 3'd3;
    rstart = rctl && s_wdata[0]; rcancel = rctl && s_wdata[1]; rclr = rctl && s_wdata[5];
    wstart = wctl && s_wdata[0]; wcancel = wctl && s_wdata[1]; wclr = wctl && s_wdata[5];
    part_we = s_we && s_sel == 3'd7 && !m_rbusy && !m_wbusy;
    rdone_evt = 0; wdone_evt = 0; rpush = 0; wpop = 0; word = 0;
    // read direction
    if (rcancel) begin
      m_rbusy = 0; m_ridx = 0; m_rasm = 0;
    end else if (rstart && !m_rbusy) begin
      m_rrem = m_rcnt; m_raddr = m_rareg; m_ridx = 0; m_rasm = 0;
      m_rbusy = (m_rcnt != 0);
      if (m_rcnt == 0) rdone_evt = 1;
    end else if (rtake) begin
      b = bdata(m_raddr);
      word = m_rasm | (32'(b) << (8 * m_ridx));
      if (m_ridx == 3 || m_rrem == 1) begin rpush = 1; m_rasm = 0; end
      else m_rasm = word;
      if (m_rrem == 1) begin m_rbusy = 0; rdone_evt = 1; end
      m_rrem--; m_raddr++; m_ridx = (m_ridx + 1) % 4;
    end
    // write direction
    if (wcancel) begin
      m_wbusy = 0; m_widx = 0;
    end else if (wstart && !m_wbusy) begin
      m_wrem = m_wcnt; m_waddr = m_wareg; m_widx = 0;
      m_wbusy = (m_wcnt != 0);
      if (m_wcnt == 0) wdone_evt = 1;
    end else if (wtake) begin
      if (m_widx == 3 || m_wrem == 1) wpop = 1;
      if (m_wrem == 1) begin m_wbusy = 0; wdone_evt = 1; m_widx = 0; end
      else m_widx = (m_widx + 1) % 4;
      m_wrem--; m_waddr++;
    end
    if (rdone_evt) m_rdone = 1; else if (rclr) m_rdone = 0;
    if (wdone_evt) m_wdone = 1; else if (wclr) m_wdone = 0;
    // buffers
    pop_ok = s_pop && rq.size() > 0;
    push_ok = s_push && wq.size() < DEPTH - m_part;
    if (part_we) begin
      rq.delete(); wq.delete();
      cval = s_wdata;
      if (cval == 0) m_part = 1;
      else if (cval >= DEPTH) m_part = DEPTH - 1;
      else m_part = int'(cval);
    end else begin
      if (pop_ok) void'(rq.pop_front());
      if (rpush) rq.push_back(word);
      if (wpop) void'(wq.pop_front());
      if (push_ok) wq.push_back(s_pdata);
    end
    // register file
    if (s_we && s_sel == 3'd1) m_rcnt = {16'b0, s_wdata[15:0]};
    if (s_we && s_sel == 3'd2) m_rareg = s_wdata;
    if (s_we && s_sel == 3'd4) m_wcnt = {16'b0, s_wdata[15:0]};
    if (s_we && s_sel == 3'd5) m_wareg = s_wdata;
  endtask

  task automatic cyc();
    bit exp_fr, exp_fw;
    @(negedge clk);
    ncyc++;
    reg_we = s_we; reg_sel = s_sel; reg_wdata = s_wdata;
    hrd_pop = s_pop; hwr_push = s_push; hwr_data = s_pdata;
    fr_vld = (vld_mode == 0) ? 1'b1 : (vld_mode == 1) ? (ncyc % 3 != 2) : 1'b0;
    fw_ack = (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? (ncyc % 3 != 1) : 1'b0;
    fr_byte = bdata(m_raddr);
    #1;
    last_rdata = reg_rdata; last_hrd = hrd_data; last_fr_req = fr_req;
    last_fw_req = fw_req; last_fw_byte = fw_byte; last_fw_addr = fw_addr;
    exp_fr = m_rbusy && (rq.size() < m_part);
    exp_fw = m_wbusy && (wq.size() > 0);
    chk(32'(fr_req), 32'(exp_fr), "R8 fr_req");
    if (exp_fr) chk(fr_addr, m_raddr, "R2 fr_addr");
    chk(32'(fw_req), 32'(exp_fw), "R9 fw_req");
    if (exp_fw) begin
      chk(fw_addr, m_waddr, "R2 fw_addr");
      chk(32'(fw_byte), (wq[0] >> (8 * m_widx)) & 32'hff, "R9 fw_byte");
    end
    if (rq.size() > 0) chk(hrd_data, rq[0], "R3 hrd_data");
    chk(reg_rdata, m_reg(s_sel), sel_tag(s_sel));
    model_step();
  endtask

  task automatic wr_reg(input bit [2:0] sel, input bit [31:0] val);
    s_we = 1; s_sel = sel; s_wdata = val;
    cyc();
    s_we = 0; s_sel = 3'd6; s_wdata = 0;
  endtask

  task automatic rd_chk(input bit [2:0] sel, input bit [31:0] exp, input string tag);
    s_sel = sel;
    cyc();
    s_sel = 3'd6;
    chk(last_rdata, exp, tag);
  endtask

  task automatic pop_chk(input bit [31:0] exp, input string tag);
    s_pop = 1;
    cyc();
    s_pop = 0;
    chk(last_hrd, exp, tag);
  endtask

  task automatic push_word(input bit [31:0] w);
    s_push = 1; s_pdata = w;
    cyc();
    s_push = 0;
  endtask

  task automatic drain_rd(output int n);
    n = 0;
    for (int g = 0; g < 3000 && (m_rbusy || rq.size() > 0); g++) begin
      s_pop = rq.size() > 0;
      if (s_pop) n++;
      cyc();
    end
    s_pop = 0;
  endtask

  task automatic run_wr_idle();
    for (int g = 0; g < 3000 && m_wbusy; g++) cyc();
  endtask

  function automatic bit [31:0] pack4(bit [31:0] a);
    return {bdata(a + 3), bdata(a + 2), bdata(a + 1), bdata(a)};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    m_part = DEPTH / 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd0, 32'h0, "R1 read control");
    rd_chk(3'd3, 32'h0, "R1 write control");
    rd_chk(3'd6, 32'h0, "R1 levels");
    rd_chk(3'd7, 32'd8, "R1 partition default");
    chk(32'(last_fr_req | last_fw_req), 0, "R1 requests");

    // R2 R3 R4: 10-byte read with stalling flash side
    vld_mode = 1;
    wr_reg(3'd1, 32'd10);
    wr_reg(3'd2, 32'h100);
    wr_reg(3'd0, 32'h1);
    rd_chk(3'd0, 32'h4, "R2 in-progress after start");
    for (int g = 0; g < 200 && m_rbusy; g++) cyc();
    rd_chk(3'd0, 32'h20, "R4 done set");
    wr_reg(3'd0, 32'h0);
    rd_chk(3'd0, 32'h20, "R4 zero write keeps done");
    rd_chk(3'd6, 32'd3, "R7 read level");
    pop_chk(pack4(32'h100), "R3 word 0");
    pop_chk(pack4(32'h104), "R3 word 1");
    pop_chk({16'h0, bdata(32'h109), bdata(32'h108)}, "R3 padded tail");
    wr_reg(3'd0, 32'h20);
    rd_chk(3'd0, 32'h0, "R4 done cleared");

    // R8 back-pressure: 40 bytes into an 8-word partition
    vld_mode = 0;
    wr_reg(3'd1, 32'd40);
    wr_reg(3'd2, 32'h200);
    wr_reg(3'd0, 32'h1);
    repeat (45) cyc();
    rd_chk(3'd6, 32'd8, "R8 read level full");
    chk(32'(last_fr_req), 0, "R8 request held");
    drain_rd(n);
    chk(32'(n), 32'd10, "R8 word count after resume");
    wr_reg(3'd0, 32'h20);

    // R6 restart while busy
    vld_mode = 1;
    wr_reg(3'd1, 32'd20);
    wr_reg(3'd2, 32'h500);
    wr_reg(3'd0, 32'h1);
    repeat (3) cyc();
    wr_reg(3'd1, 32'd99);
    wr_reg(3'd2, 32'h900);
    wr_reg(3'd0, 32'h1);
    drain_rd(n);
    chk(32'(n), 32'd5, "R6 original length kept");
    rd_chk(3'd1, 32'd99, "R6 count register holds new value");
    wr_reg(3'd0, 32'h20);

    // R5 cancel
    wr_reg(3'd1, 32'd100);
    wr_reg(3'd2, 32'h700);
    wr_reg(3'd0, 32'h1);
    repeat (5) cyc();
    wr_reg(3'd0, 32'h2);
    rd_chk(3'd0, 32'h0, "R5 idle without done");
    chk(32'(last_fr_req), 0, "R5 request low");
    drain_rd(n);

    // R11 zero count
    wr_reg(3'd1, 32'd0);
    wr_reg(3'd0, 32'h1);
    rd_chk(3'd0, 32'h20, "R11 done without busy");
    chk(32'(last_fr_req), 0, "R11 no request");
    wr_reg(3'd0, 32'h20);

    // R9 write with empty buffer, then feed it
    ack_mode = 1;
    wr_reg(3'd4, 32'd8);
    wr_reg(3'd5, 32'h2000);
    wr_reg(3'd3, 32'h1);
    cyc();
    chk(32'(last_fw_req), 0, "R9 held while empty");
    push_word(32'hA3A2A1A0);
    chk(32'(last_fw_req), 0, "R9 held until word lands");
    cyc();
    chk(32'(last_fw_byte), 32'hA0, "R9 lowest lane first");
    chk(last_fw_addr, 32'h2000, "R9 start address");
    push_word(32'hB3B2B1B0);
    run_wr_idle();
    rd_chk(3'd3, 32'h20, "R4 write done");
    rd_chk(3'd6, 32'h0, "R7 write buffer drained");
    wr_reg(3'd3, 32'h20);

    // R7 R9: 11-byte write with words pre-loaded
    push_word(32'h11223344);
    push_word(32'h55667788);
    push_word(32'h99AABBCC);
    rd_chk(3'd6, 32'h30000, "R7 write level field");
    wr_reg(3'd4, 32'd11);
    wr_reg(3'd5, 32'h3000);
    wr_reg(3'd3, 32'h1);
    run_wr_idle();
    rd_chk(3'd6, 32'h0, "R9 partial tail word released");

    // R10 full write partition ignores pushes
    for (int k = 0; k < 9; k++) push_word(32'h1000 + k);
    rd_chk(3'd6, 32'h80000, "R10 write partition full");
    ack_mode = 0;
    wr_reg(3'd4, 32'd32);
    wr_reg(3'd3, 32'h1);
    run_wr_idle();
    rd_chk(3'd6, 32'h0, "R10 drained");
    wr_reg(3'd3, 32'h20);

    // R10 partition clamp and busy guard
    wr_reg(3'd7, 32'd0);
    rd_chk(3'd7, 32'd1, "R10 clamp low");
    wr_reg(3'd7, 32'd100);
    rd_chk(3'd7, 32'd15, "R10 clamp high");
    wr_reg(3'd7, 32'd2);
    wr_reg(3'd1, 32'd12);
    wr_reg(3'd2, 32'h800);
    wr_reg(3'd0, 32'h1);
    repeat (20) cyc();
    rd_chk(3'd6, 32'd2, "R8 smaller partition full");
    wr_reg(3'd7, 32'd5);
    rd_chk(3'd7, 32'd2, "R10 write ignored while busy");
    drain_rd(n);
    chk(32'(n), 32'd3, "R8 resume at small partition");
    wr_reg(3'd7, 32'd8);
    rd_chk(3'd7, 32'd8, "R10 restored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule